// File: doc/BRIEF.md
# Three-Wire Addressed Configuration Register File

This block takes a write-only three-wire serial stream (a serial clock, a data line and a latch strobe) and turns it into the static control fields of a frequency-synthesizer core. Frames are 24 bits long and arrive most significant bit first. The final two bits of each frame pick one of four 22-bit holding registers. When the latch strobe rises, the 22 upper bits of the frame are copied into the chosen register. All three serial wires are asynchronous to the core clock. They are first brought into the core clock domain through a synchronizer chain, and their edges are then found by comparing against the previous sample.

Named decode fields come out of the four registers: the reference divider, the charge-pump weights and polarity, the feedback counters and fraction, the prescaler choice, the lock-detect selector and the fractional modulus. The block also computes two output pins. Each pin has a level and an output-enable, and the pins work in one of three modes: plain level outputs, a fastlock damping switch tied to the high charge-pump weight, or a test mode. The block also makes a power-down request. That request can take effect at once or wait for the present charge-pump pulse to end, and the chip-enable input overrides it.

Top module: `cfg3w_regfile`

## Requirements
- R1: A frame is shifted in MSB first on rising serial-clock edges. Its last two bits form the address. A rising latch strobe copies frame bits 23..2 into the register picked by that address: 00 auxiliary, 01 pin control, 10 reference, 11 feedback. The other registers are left unchanged, and shifting with no latch edge changes no output.
- R2: Reference register decode: bits 14..0 give `ref_div`, bit 15 gives `pd_polarity`, bits 19..16 give `cp_code` (bit 19 is the 8x weight), bit 20 gives `dbl_en` and bit 21 gives `dly_mode`.
- R3: Feedback register decode: bits 3..0 give `frac_num`, bits 8..4 give `a_count`, bits 18..9 give `b_count`, bit 19 gives `presc_wide`, bit 20 is the power-down request and bit 21 gives `cnt_reset`.
- R4: Auxiliary register decode: bits 19..17 give `ld_sel` and bit 20 gives `frac_mod16`. Pin-control register: bit 15 is the pin 0 level, bit 16 the pin 1 level, bit 17 test, bit 18 fastlock and bit 19 the power-down mode (1 = synchronous).
- R5: `cp_steps` equals `cp_code` plus one, counted in 100 µA units. It is 1 for code 0000 and 16 for code 1111.
- R6: When the test bit is 1, `test_mode` is 1 and both pins are undriven (oe = 0, level = 0), whatever the fastlock bit holds.
- R7: When fastlock is 1 and test is 0, the pin level bits are ignored. Pin 1 is undriven. Pin 0 is driven low while the 8x weight is 1 and is undriven while it is 0.
- R8: When test and fastlock are both 0, both pins are driven (oe = 1) at their own level bits.
- R9: In asynchronous mode, a power-down request raises `pwr_down` within a few cycles of the latch, even while `cp_active` is high.
- R10: In synchronous mode, a power-down request does not raise `pwr_down` while `cp_active` is high. It raises `pwr_down` on the first clock after `cp_active` falls.
- R11: While `chip_en` is 0, `pwr_down` is 1 whatever the request bit holds, and frames are still latched and decoded.
- R12: After reset every register is zero. All decoded fields are zero, `cp_steps` is 1, both pins are driven low and `pwr_down` equals the inverse of `chip_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Latch strobe, rising edge writes |
| chip_en | input | 1 | Chip enable; low forces power-down |
| cp_active | input | 1 | Charge-pump pulse in progress |
| ref_div | output | 15 | Reference divide ratio |
| pd_polarity | output | 1 | Phase detector polarity |
| cp_code | output | 4 | Charge-pump weight code |
| cp_steps | output | 5 | Charge-pump current in 100 µA steps |
| dbl_en | output | 1 | Supply doubler enable |
| dly_mode | output | 1 | Delay-line calibration speed |
| frac_num | output | 4 | Fractional numerator |
| a_count | output | 5 | Swallow counter value |
| b_count | output | 10 | Main feedback counter value |
| presc_wide | output | 1 | 1 selects the 32/33 prescaler |
| cnt_reset | output | 1 | Divider counter reset |
| frac_mod16 | output | 1 | 1 selects modulus 16, 0 selects 15 |
| ld_sel | output | 3 | Lock-detect output selector |
| test_mode | output | 1 | Pin test mode active |
| pin0_level | output | 1 | Pin 0 drive level |
| pin0_oe | output | 1 | Pin 0 output enable |
| pin1_level | output | 1 | Pin 1 drive level |
| pin1_oe | output | 1 | Pin 1 output enable |
| pwr_down | output | 1 | Effective power-down |

## Verification
The bench builds the block with its default two-stage synchronizer and the standard 24-bit frame with a 2-bit address, which gives all four registers and every field position. The serial wires are held for several core cycles per phase. This lets every frame cross the synchronizer cleanly, so each register can be written with bit patterns that tell adjacent fields apart. A partial frame shifted without a latch edge shows that only the strobe commits data. Holding `cp_active` high across a latch, and then dropping it, covers both power-down timings.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

    localparam int FRAME_W = 24;
    localparam int ADDR_W  = 2;
    localparam int WORD_W  = FRAME_W - ADDR_W;
    localparam int BANK_N  = 1 << ADDR_W;

    localparam int IDX_AUX = 0;
    localparam int IDX_PIN = 1;
    localparam int IDX_REF = 2;
    localparam int IDX_FB  = 3;

    typedef struct packed {
        logic        dly_mode;
        logic        dbl_en;
        logic [3:0]  cp_code;
        logic        pd_pol;
        logic [14:0] ref_div;
    } ref_word_t;

    typedef struct packed {
        logic        cnt_rst;
        logic        pd_req;
        logic        presc_wide;
        logic [9:0]  b_cnt;
        logic [4:0]  a_cnt;
        logic [3:0]  frac;
    } fb_word_t;

    typedef struct packed {
        logic        rsv_hi;
        logic        mod16;
        logic [2:0]  ld_sel;
        logic [16:0] rsv_lo;
    } aux_word_t;

    typedef struct packed {
        logic [1:0]  rsv_hi;
        logic        pd_sync;
        logic        fastlock;
        logic        test;
        logic        lvl1;
        logic        lvl0;
        logic [14:0] rsv_lo;
    } pin_word_t;

    typedef enum logic [1:0] {
        PIN_GPIO = 2'd0,
        PIN_FAST = 2'd1,
        PIN_TEST = 2'd2
    } pin_mode_e;

    function automatic pin_mode_e pick_mode(input pin_word_t w);
        if (w.test)
            return PIN_TEST;
        else if (w.fastlock)
            return PIN_FAST;
        else
            return PIN_GPIO;
    endfunction

    function automatic logic [4:0] cp_step_count(input logic [3:0] code);
        return {1'b0, code} + 5'd1;
    endfunction

endpackage

// File: rtl/cfg3w_serial_in.sv
module cfg3w_serial_in #(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_W     = 24,
    parameter int ADDR_W      = 2,
    localparam int WORD_W     = FRAME_W - ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_latch,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data
);

    logic [SYNC_STAGES-1:0] clk_sync, dat_sync, le_sync;
    logic                   clk_s, dat_s, le_s;
    logic                   clk_d, le_d;
    logic [FRAME_W-1:0]     frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sync <= '0;
            dat_sync <= '0;
            le_sync  <= '0;
        end else begin
            clk_sync <= {clk_sync[SYNC_STAGES-2:0], ser_clk};
            dat_sync <= {dat_sync[SYNC_STAGES-2:0], ser_data};
            le_sync  <= {le_sync[SYNC_STAGES-2:0], ser_latch};
        end
    end

    assign clk_s = clk_sync[SYNC_STAGES-1];
    assign dat_s = dat_sync[SYNC_STAGES-1];
    assign le_s  = le_sync[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_d <= 1'b0;
            le_d  <= 1'b0;
            frame <= '0;
        end else begin
            clk_d <= clk_s;
            le_d  <= le_s;
            if (clk_s && !clk_d)
                frame <= {frame[FRAME_W-2:0], dat_s};
        end
    end

    assign wr_en   = le_s && !le_d;
    assign wr_addr = frame[ADDR_W-1:0];
    assign wr_data = frame[FRAME_W-1:ADDR_W];

endmodule

// File: rtl/cfg3w_bank.sv
module cfg3w_bank #(
    parameter int ADDR_W = 2,
    parameter int WORD_W = 22,
    localparam int BANK_N = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [BANK_N-1:0][WORD_W-1:0] words
);

    for (genvar g = 0; g < BANK_N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                words[g] <= wr_data;
        end
    end

endmodule

// File: rtl/cfg3w_pins.sv
module cfg3w_pins
    import cfg3w_pkg::*;
(
    input  pin_word_t pw,
    input  logic      cp8x,
    output logic      test_mode,
    output logic      pin0_level,
    output logic      pin0_oe,
    output logic      pin1_level,
    output logic      pin1_oe
);

    pin_mode_e mode;

    assign mode = pick_mode(pw);

    always_comb begin
        test_mode  = 1'b0;
        pin0_level = 1'b0;
        pin0_oe    = 1'b0;
        pin1_level = 1'b0;
        pin1_oe    = 1'b0;
        case (mode)
            PIN_TEST: test_mode = 1'b1;
            PIN_FAST: pin0_oe   = cp8x;
            default: begin
                pin0_oe    = 1'b1;
                pin1_oe    = 1'b1;
                pin0_level = pw.lvl0;
                pin1_level = pw.lvl1;
            end
        endcase
    end

endmodule

// File: rtl/cfg3w_pwr.sv
module cfg3w_pwr (
    input  logic clk,
    input  logic rst,
    input  logic chip_en,
    input  logic pd_req,
    input  logic pd_sync,
    input  logic cp_active,
    output logic pd_held,
    output logic pwr_down
);

    always_ff @(posedge clk) begin
        if (rst)
            pd_held <= 1'b0;
        else if (!pd_req)
            pd_held <= 1'b0;
        else if (!pd_sync || !cp_active)
            pd_held <= 1'b1;
    end

    assign pwr_down = !chip_en || pd_held;

endmodule

// File: rtl/cfg3w_regfile.sv
module cfg3w_regfile
    import cfg3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_clk,
    input  logic        ser_data,
    input  logic        ser_latch,
    input  logic        chip_en,
    input  logic        cp_active,
    output logic [14:0] ref_div,
    output logic        pd_polarity,
    output logic [3:0]  cp_code,
    output logic [4:0]  cp_steps,
    output logic        dbl_en,
    output logic        dly_mode,
    output logic [3:0]  frac_num,
    output logic [4:0]  a_count,
    output logic [9:0]  b_count,
    output logic        presc_wide,
    output logic        cnt_reset,
    output logic        frac_mod16,
    output logic [2:0]  ld_sel,
    output logic        test_mode,
    output logic        pin0_level,
    output logic        pin0_oe,
    output logic        pin1_level,
    output logic        pin1_oe,
    output logic        pwr_down
);

    logic                          wr_en;
    logic [ADDR_W-1:0]             wr_addr;
    logic [WORD_W-1:0]             wr_data;
    logic [BANK_N-1:0][WORD_W-1:0] words;
    logic                          pd_held;

    ref_word_t refw;
    fb_word_t  fbw;
    aux_word_t auxw;
    pin_word_t pinw;

    cfg3w_serial_in #(
        .SYNC_STAGES(SYNC_STAGES),
        .FRAME_W    (FRAME_W),
        .ADDR_W     (ADDR_W)
    ) u_serial (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_latch(ser_latch),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    cfg3w_bank #(
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .words  (words)
    );

    assign refw = ref_word_t'(words[IDX_REF]);
    assign fbw  = fb_word_t'(words[IDX_FB]);
    assign auxw = aux_word_t'(words[IDX_AUX]);
    assign pinw = pin_word_t'(words[IDX_PIN]);

    assign ref_div     = refw.ref_div;
    assign pd_polarity = refw.pd_pol;
    assign cp_code     = refw.cp_code;
    assign cp_steps    = cp_step_count(refw.cp_code);
    assign dbl_en      = refw.dbl_en;
    assign dly_mode    = refw.dly_mode;
    assign frac_num    = fbw.frac;
    assign a_count     = fbw.a_cnt;
    assign b_count     = fbw.b_cnt;
    assign presc_wide  = fbw.presc_wide;
    assign cnt_reset   = fbw.cnt_rst;
    assign frac_mod16  = auxw.mod16;
    assign ld_sel      = auxw.ld_sel;

    cfg3w_pins u_pins (
        .pw        (pinw),
        .cp8x      (refw.cp_code[3]),
        .test_mode (test_mode),
        .pin0_level(pin0_level),
        .pin0_oe   (pin0_oe),
        .pin1_level(pin1_level),
        .pin1_oe   (pin1_oe)
    );

    cfg3w_pwr u_pwr (
        .clk      (clk),
        .rst      (rst),
        .chip_en  (chip_en),
        .pd_req   (fbw.pd_req),
        .pd_sync  (pinw.pd_sync),
        .cp_active(cp_active),
        .pd_held  (pd_held),
        .pwr_down (pwr_down)
    );

endmodule

// File: rtl/cfg3w_checker.sv
module cfg3w_checker
    import cfg3w_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [WORD_W-1:0]             wr_data,
    input logic [BANK_N-1:0][WORD_W-1:0] words,
    input logic                          test_mode,
    input logic                          fastlock,
    input logic                          cp8x,
    input logic                          pin0_level,
    input logic                          pin0_oe,
    input logic                          pin1_oe,
    input logic                          pd_req,
    input logic                          pd_sync,
    input logic                          cp_active,
    input logic                          pd_held,
    input logic                          chip_en,
    input logic                          pwr_down
);

    p_write_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> words[$past(wr_addr)] == $past(wr_data));

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(words));

    p_test_off_r6: assert property (@(posedge clk) disable iff (rst)
        test_mode |-> (!pin0_oe && !pin1_oe));

    p_fast_pins_r7: assert property (@(posedge clk) disable iff (rst)
        (fastlock && !test_mode) |-> (!pin1_oe && (pin0_oe == cp8x) && !pin0_level));

    p_async_pd_r9: assert property (@(posedge clk) disable iff (rst)
        (pd_req && !pd_sync) |=> pwr_down);

    p_sync_wait_r10: assert property (@(posedge clk) disable iff (rst)
        (pd_req && pd_sync && cp_active && !pd_held) |=> !pd_held);

    p_chip_off_r11: assert property (@(posedge clk) disable iff (rst)
        !chip_en |-> pwr_down);

endmodule

bind cfg3w_regfile cfg3w_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .words     (words),
    .test_mode (test_mode),
    .fastlock  (pinw.fastlock),
    .cp8x      (refw.cp_code[3]),
    .pin0_level(pin0_level),
    .pin0_oe   (pin0_oe),
    .pin1_oe   (pin1_oe),
    .pd_req    (fbw.pd_req),
    .pd_sync   (pinw.pd_sync),
    .cp_active (cp_active),
    .pd_held   (pd_held),
    .chip_en   (chip_en),
    .pwr_down  (pwr_down)
);

// File: tb/cfg3w_regfile_tb.sv
module cfg3w_regfile_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0;
    logic chip_en = 1'b1, cp_active = 1'b0;

    logic [14:0] ref_div;
    logic        pd_polarity;
    logic [3:0]  cp_code;
    logic [4:0]  cp_steps;
    logic        dbl_en, dly_mode;
    logic [3:0]  frac_num;
    logic [4:0]  a_count;
    logic [9:0]  b_count;
    logic        presc_wide, cnt_reset, frac_mod16;
    logic [2:0]  ld_sel;
    logic        test_mode, pin0_level, pin0_oe, pin1_level, pin1_oe, pwr_down;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg3w_regfile u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .chip_en(chip_en), .cp_active(cp_active),
        .ref_div(ref_div), .pd_polarity(pd_polarity), .cp_code(cp_code),
        .cp_steps(cp_steps), .dbl_en(dbl_en), .dly_mode(dly_mode),
        .frac_num(frac_num), .a_count(a_count), .b_count(b_count),
        .presc_wide(presc_wide), .cnt_reset(cnt_reset), .frac_mod16(frac_mod16),
        .ld_sel(ld_sel), .test_mode(test_mode), .pin0_level(pin0_level),
        .pin0_oe(pin0_oe), .pin1_level(pin1_level), .pin1_oe(pin1_oe),
        .pwr_down(pwr_down)
    );

    typedef struct {
        string       req;
        int          sel;
        logic [31:0] exp;
    } chk_t;

    chk_t        q[$];
    int          checks = 0;
    int          errors = 0;
    bit          done   = 0;
    logic [21:0] model [4];

    function automatic logic [31:0] obs(input int sel);
        case (sel)
            0:  return 32'(ref_div);
            1:  return 32'(pd_polarity);
            2:  return 32'(cp_code);
            3:  return 32'(cp_steps);
            4:  return 32'(dbl_en);
            5:  return 32'(dly_mode);
            6:  return 32'(frac_num);
            7:  return 32'(a_count);
            8:  return 32'(b_count);
            9:  return 32'(presc_wide);
            10: return 32'(cnt_reset);
            11: return 32'(frac_mod16);
            12: return 32'(ld_sel);
            13: return 32'(test_mode);
            14: return 32'(pin0_level);
            15: return 32'(pin0_oe);
            16: return 32'(pin1_level);
            17: return 32'(pin1_oe);
            default: return 32'(pwr_down);
        endcase
    endfunction

    task automatic push(input string req, input int sel, input logic [31:0] exp);
        chk_t c;
        c.req = req;
        c.sel = sel;
        c.exp = exp;
        q.push_back(c);
    endtask

    // monitor: pops expected items and compares them with the ports
    always @(negedge clk) begin
        while (q.size() > 0) begin
            chk_t c;
            c = q.pop_front();
            checks++;
            if (obs(c.sel) !== c.exp) begin
                errors++;
                $display("FAIL %s field %0d: actual %0h expected %0h",
                         c.req, c.sel, obs(c.sel), c.exp);
            end
        end
    end

    task automatic drain();
        repeat (2) @(negedge clk);
    endtask

    // expected decode of every field, from the bench model and the requirements
    task automatic expect_fields(input string ctx);
        logic [21:0] rw, fw, aw, pw;
        logic        t, f, c8;
        rw = model[2]; fw = model[3]; aw = model[0]; pw = model[1];
        t = pw[17]; f = pw[18]; c8 = rw[19];
        push({ctx, " R2 ref_div"},  0, 32'(rw[14:0]));
        push({ctx, " R2 polarity"}, 1, 32'(rw[15]));
        push({ctx, " R2 cp_code"},  2, 32'(rw[19:16]));
        push({ctx, " R5 cp_steps"}, 3, 32'(rw[19:16]) + 32'd1);
        push({ctx, " R2 dbl_en"},   4, 32'(rw[20]));
        push({ctx, " R2 dly_mode"}, 5, 32'(rw[21]));
        push({ctx, " R3 frac"},     6, 32'(fw[3:0]));
        push({ctx, " R3 a_count"},  7, 32'(fw[8:4]));
        push({ctx, " R3 b_count"},  8, 32'(fw[18:9]));
        push({ctx, " R3 presc"},    9, 32'(fw[19]));
        push({ctx, " R3 cnt_rst"}, 10, 32'(fw[21]));
        push({ctx, " R4 mod16"},   11, 32'(aw[20]));
        push({ctx, " R4 ld_sel"},  12, 32'(aw[19:17]));
        push({ctx, " R6 test"},    13, 32'(t));
        if (t) begin
            push({ctx, " R6 p0lvl"}, 14, 32'd0);
            push({ctx, " R6 p0oe"},  15, 32'd0);
            push({ctx, " R6 p1lvl"}, 16, 32'd0);
            push({ctx, " R6 p1oe"},  17, 32'd0);
        end else if (f) begin
            push({ctx, " R7 p0lvl"}, 14, 32'd0);
            push({ctx, " R7 p0oe"},  15, 32'(c8));
            push({ctx, " R7 p1lvl"}, 16, 32'd0);
            push({ctx, " R7 p1oe"},  17, 32'd0);
        end else begin
            push({ctx, " R8 p0lvl"}, 14, 32'(pw[15]));
            push({ctx, " R8 p0oe"},  15, 32'd1);
            push({ctx, " R8 p1lvl"}, 16, 32'(pw[16]));
            push({ctx, " R8 p1oe"},  17, 32'd1);
        end
        drain();
    endtask

    task automatic shift_frame(input logic [1:0] addr, input logic [21:0] data);
        logic [23:0] fr;
        fr = {data, addr};
        for (int i = 23; i >= 0; i--) begin
            @(negedge clk) ser_data = fr[i];
            repeat (HOLD) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HOLD) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] addr, input logic [21:0] data);
        shift_frame(addr, data);
        ser_latch = 1'b1;
        repeat (2*HOLD) @(negedge clk);
        ser_latch = 1'b0;
        repeat (2*HOLD) @(negedge clk);
        model[addr] = data;
    endtask

    function automatic logic [21:0] w_ref(input logic dly, input logic dbl,
                                          input logic [3:0] code, input logic pol,
                                          input logic [14:0] div);
        return {dly, dbl, code, pol, div};
    endfunction

    function automatic logic [21:0] w_fb(input logic crst, input logic pd,
                                         input logic pw, input logic [9:0] b,
                                         input logic [4:0] a, input logic [3:0] fr);
        return {crst, pd, pw, b, a, fr};
    endfunction

    function automatic logic [21:0] w_pin(input logic sync, input logic fast,
                                          input logic test, input logic l1, input logic l0);
        return {2'b00, sync, fast, test, l1, l0, 15'd0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) model[k] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        expect_fields("R12");
        push("R12 pwr_down", 18, 32'd0);
        drain();

        // R2 R5: reference register patterns and code boundaries
        write_reg(2'b10, w_ref(1'b1, 1'b0, 4'b0101, 1'b1, 15'h5A3C));
        expect_fields("R1");
        write_reg(2'b10, w_ref(1'b0, 1'b1, 4'b1111, 1'b0, 15'd3));
        expect_fields("R5 max");
        write_reg(2'b10, w_ref(1'b1, 1'b1, 4'b0000, 1'b1, 15'h7FFF));
        expect_fields("R5 min");

        // R3: feedback register patterns
        write_reg(2'b11, w_fb(1'b1, 1'b0, 1'b1, 10'h2B5, 5'h13, 4'hA));
        expect_fields("R3 a");
        write_reg(2'b11, w_fb(1'b0, 1'b0, 1'b0, 10'h14A, 5'h0C, 4'h5));
        expect_fields("R3 b");

        // R4: auxiliary register
        write_reg(2'b00, {1'b0, 1'b1, 3'b110, 17'h1FFFF});
        expect_fields("R4 aux");

        // R8: plain pin mode, both level combinations
        write_reg(2'b01, w_pin(1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        expect_fields("R8 a");
        write_reg(2'b01, w_pin(1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
        expect_fields("R8 b");

        // R1: shifting without a latch edge leaves everything unchanged
        shift_frame(2'b10, 22'h3FFFFF);
        repeat (10) @(negedge clk);
        expect_fields("R1 nolatch");

        // R7: fastlock with 8x weight high then low, level bits set and ignored
        write_reg(2'b10, w_ref(1'b0, 1'b0, 4'b1000, 1'b0, 15'd100));
        write_reg(2'b01, w_pin(1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
        expect_fields("R7 8x on");
        write_reg(2'b10, w_ref(1'b0, 1'b0, 4'b0111, 1'b0, 15'd100));
        expect_fields("R7 8x off");

        // R6: test overrides fastlock
        write_reg(2'b10, w_ref(1'b0, 1'b0, 4'b1000, 1'b0, 15'd100));
        write_reg(2'b01, w_pin(1'b0, 1'b1, 1'b1, 1'b1, 1'b1));
        expect_fields("R6");

        // R9: asynchronous power-down ignores charge-pump activity
        write_reg(2'b01, w_pin(1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        cp_active = 1'b1;
        write_reg(2'b11, w_fb(1'b0, 1'b1, 1'b0, 10'd40, 5'd3, 4'd0));
        push("R9 async pd", 18, 32'd1);
        drain();
        write_reg(2'b11, w_fb(1'b0, 1'b0, 1'b0, 10'd40, 5'd3, 4'd0));
        push("R9 release", 18, 32'd0);
        drain();

        // R10: synchronous power-down waits for the pulse to end
        write_reg(2'b01, w_pin(1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        write_reg(2'b11, w_fb(1'b0, 1'b1, 1'b0, 10'd40, 5'd3, 4'd0));
        repeat (5) @(negedge clk);
        push("R10 held off", 18, 32'd0);
        drain();
        cp_active = 1'b0;
        repeat (2) @(negedge clk);
        push("R10 engaged", 18, 32'd1);
        drain();
        cp_active = 1'b1;
        repeat (3) @(negedge clk);
        push("R10 stays", 18, 32'd1);
        drain();
        cp_active = 1'b0;
        write_reg(2'b11, w_fb(1'b0, 1'b0, 1'b0, 10'd40, 5'd3, 4'd0));
        push("R10 release", 18, 32'd0);
        drain();

        // R11: chip enable overrides, writes still land
        chip_en = 1'b0;
        repeat (2) @(negedge clk);
        push("R11 forced", 18, 32'd1);
        drain();
        write_reg(2'b10, w_ref(1'b1, 1'b0, 4'b0011, 1'b1, 15'h1234));
        expect_fields("R11 write");
        push("R11 still", 18, 32'd1);
        drain();
        chip_en = 1'b1;
        repeat (2) @(negedge clk);
        push("R11 back", 18, 32'd0);
        drain();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule